// File: doc/BRIEF.md
# SPI Slave Memory-Access Bridge

This block lets an external SPI master read and write a local byte-wide memory space with 16-bit addresses. It works as a serial slave in clock mode 0, most significant bit first. Every frame opens with a command byte, continues with a two-byte address, and may then stream any number of data bytes. The access address steps forward by one after each data byte, so a long run of adjacent locations can be moved in a single chip-select period. On the local side the block drives a simple parallel bus: a one-cycle write strobe, and a read strobe whose data comes back on the following cycle.

The serial pins are brought into the system clock domain through a synchronizer, and all framing logic runs on the system clock. Firmware sees the command byte and the starting address of the latest frame as held copies. It also sees a sticky end-of-frame flag, which it clears by writing zero. An enable input gates the whole port. While the port is disabled, the pins are handed back to their default function and serial activity is ignored.

Top module: `spi_mem_bridge`

## Requirements
- R1: While `csN` is high or `portEn` is low, `misoOe` is 0, no memory strobe is issued, and `sclk`/`mosi` activity changes neither `spiFlag` nor the held copies.
- R2: `pinAltSel` is 1 exactly when `portEn` is 0.
- R3: Bits are taken on rising `sclk`, most significant first. The first 8 bits form the command and load `cmdCopy`. The next 16 bits form the address (high byte first) and load `addrCopy`. Both copies reset to 0, and a frame that ends before the address is complete leaves `addrCopy` unchanged.
- R4: In a write frame, each completed data byte n (counting from 0) produces exactly one `memWe` pulse with `memAddr` = start address + n (modulo 2^16) and `memWdata` = that byte. `memWe` and `memRe` are never high together.
- R5: In a read frame, data byte n is the memory content at start address + n (modulo 2^16). It is shifted out MSB first, changes on falling `sclk`, and its first bit is valid before the first data rising edge.
- R6: `addrCopy` keeps the starting address for the whole frame and does not follow the increments.
- R7: If `csN` rises partway through a data byte, that partial byte is discarded and causes no memory write.
- R8: `spiFlag` is set when `csN` rises after at least one rising `sclk` edge in the frame, including command-only frames. A `csN` pulse with no clock edges leaves it unchanged.
- R9: `spiFlag` resets to 0. It is cleared only by a firmware write (`fwFlagWe`) with `fwFlagWdata` = 0; a firmware write of 1 has no effect.
- R10: Each written byte pulses `wrIrq` once, unless command bit 6 is 1, in which case the write is silent.
- R11: Command bit 7 = 1 selects a read and 0 selects a write. Bits 5..0 are reserved and are only captured in `cmdCopy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portEn | input | 1 | Port enable from firmware |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | Serial data from master |
| misoOut | output | 1 | Serial data to master |
| misoOe | output | 1 | Output enable for misoOut (0 = high impedance) |
| pinAltSel | output | 1 | 1 = pins serve their default alternate function |
| memAddr | output | 16 | Local bus address |
| memWdata | output | 8 | Local bus write data |
| memWe | output | 1 | Local bus write strobe |
| memRe | output | 1 | Local bus read strobe |
| memRdata | input | 8 | Local bus read data, valid the cycle after memRe |
| wrIrq | output | 1 | Pulse per non-silent written byte |
| cmdCopy | output | 8 | Held command byte of the latest frame |
| addrCopy | output | 16 | Held starting address of the latest frame |
| spiFlag | output | 1 | Sticky end-of-frame flag |
| fwFlagWe | input | 1 | Firmware write strobe for the flag |
| fwFlagWdata | input | 1 | Firmware write value for the flag |

## Verification
The bench targets an address stream that crosses a byte boundary and one that wraps from 0xFFFF to 0x0000. A design that increments only the low byte, or that reports the running address in the copy, would return the wrong byte or the wrong `addrCopy`. A frame cut off in the middle of a data byte checks that no write leaks out; a design that commits partial bytes would emit an unexpected `memWe`, which the per-clock write monitor catches. A command-only frame, a chip-select pulse with no clocks and a frame sent while disabled together separate the cases that set the flag from those that must not, and a firmware write of 1 checks that the flag cannot be disturbed that way.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DATA
  } phase_e;

  // Per-cycle requests from control to datapath
  typedef struct packed {
    logic shiftIn;   // take one serial bit
    logic capCmd;    // command byte complete
    logic capAddr;   // address complete
    logic loadTx;    // start shifting a new read byte
    logic shiftTx;   // advance the read byte by one bit
    logic issueRd;   // fetch a byte from the local bus
    logic issueWr;   // store a byte on the local bus
    logic clearTx;   // frame inactive: clear serial state
    logic setFlag;   // frame ended
  } strobe_t;

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    portEn,
  input  logic    csSync,
  input  logic    sckSync,
  input  logic    cmdIsRead,
  output strobe_t stb,
  output logic    active
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam int ADDR_BYTES = ADDR_W / DATA_W;
  localparam int ABYTE_W = $clog2(ADDR_BYTES + 1);

  phase_e             phase, nextPhase;
  logic [BIT_W-1:0]   bitCnt;
  logic [ABYTE_W-1:0] addrBytes;
  logic               sckDly;
  logic               sckRise, sckFall, byteDone, lastAddrByte;

  assign active       = portEn & ~csSync;
  assign sckRise      = active & sckSync & ~sckDly;
  assign sckFall      = active & ~sckSync & sckDly;
  assign byteDone     = sckRise && (bitCnt == BIT_W'(DATA_W - 1));
  assign lastAddrByte = (addrBytes == ABYTE_W'(ADDR_BYTES - 1));

  always_comb begin
    stb       = '0;
    nextPhase = phase;
    if (!active) begin
      stb.clearTx = 1'b1;
      stb.setFlag = (phase != PH_IDLE) && portEn;
      nextPhase   = PH_IDLE;
    end else begin
      stb.shiftIn = sckRise;
      case (phase)
        PH_IDLE: if (sckRise) nextPhase = PH_CMD;
        PH_CMD: begin
          if (byteDone) begin
            stb.capCmd = 1'b1;
            nextPhase  = PH_ADDR;
          end
        end
        PH_ADDR: begin
          if (byteDone && lastAddrByte) begin
            stb.capAddr = 1'b1;
            stb.issueRd = cmdIsRead;
            nextPhase   = PH_DATA;
          end
        end
        PH_DATA: begin
          if (cmdIsRead) begin
            if (sckFall) begin
              if (bitCnt == '0) begin
                stb.loadTx  = 1'b1;
                stb.issueRd = 1'b1;
              end else begin
                stb.shiftTx = 1'b1;
              end
            end
          end else if (byteDone) begin
            stb.issueWr = 1'b1;
          end
        end
        default: nextPhase = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      addrBytes <= '0;
      sckDly    <= 1'b0;
    end else begin
      sckDly <= sckSync;
      phase  <= nextPhase;
      if (!active) begin
        bitCnt    <= '0;
        addrBytes <= '0;
      end else if (sckRise) begin
        bitCnt <= byteDone ? '0 : bitCnt + 1'b1;
        if (byteDone && phase == PH_ADDR) addrBytes <= addrBytes + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_bridge_dp.sv
module spi_bridge_dp
  import spi_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              mosiSync,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              fwFlagWe,
  input  logic              fwFlagWdata,
  output logic              cmdIsRead,
  output logic [DATA_W-1:0] cmdCopy,
  output logic [ADDR_W-1:0] addrCopy,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic              wrIrq,
  output logic              misoBit,
  output logic              spiFlag
);

  localparam int READ_BIT  = DATA_W - 1;
  localparam int QUIET_BIT = DATA_W - 2;

  logic [ADDR_W-2:0] rxShift;
  logic [ADDR_W-1:0] assembled;
  logic [ADDR_W-1:0] workAddr;
  logic [DATA_W-1:0] txBuf, txShift;
  logic              rdPend;

  assign assembled = {rxShift, mosiSync};
  assign cmdIsRead = cmdCopy[READ_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      cmdCopy  <= '0;
      addrCopy <= '0;
      workAddr <= '0;
      txBuf    <= '0;
      txShift  <= '0;
      misoBit  <= 1'b0;
      rdPend   <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
      memWe    <= 1'b0;
      memRe    <= 1'b0;
      wrIrq    <= 1'b0;
      spiFlag  <= 1'b0;
    end else begin
      memWe  <= 1'b0;
      memRe  <= 1'b0;
      wrIrq  <= 1'b0;
      rdPend <= memRe;
      if (rdPend) txBuf <= memRdata;

      if (stb.shiftIn) rxShift <= assembled[ADDR_W-2:0];
      if (stb.capCmd) cmdCopy <= assembled[DATA_W-1:0];
      if (stb.capAddr) begin
        addrCopy <= assembled;
        workAddr <= assembled;
      end

      if (stb.issueRd) begin
        memRe   <= 1'b1;
        memAddr <= stb.capAddr ? assembled : workAddr + ADDR_W'(1);
      end
      if (stb.loadTx) begin
        workAddr <= workAddr + ADDR_W'(1);
        misoBit  <= txBuf[DATA_W-1];
        txShift  <= {txBuf[DATA_W-2:0], 1'b0};
      end
      if (stb.shiftTx) begin
        misoBit <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end

      if (stb.issueWr) begin
        memWe    <= 1'b1;
        memAddr  <= workAddr;
        memWdata <= assembled[DATA_W-1:0];
        workAddr <= workAddr + ADDR_W'(1);
        wrIrq    <= ~cmdCopy[QUIET_BIT];
      end

      if (stb.clearTx) begin
        rxShift <= '0;
        txShift <= '0;
        misoBit <= 1'b0;
      end

      if (stb.setFlag) spiFlag <= 1'b1;
      else if (fwFlagWe && !fwFlagWdata) spiFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge
  import spi_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              misoOut,
  output logic              misoOe,
  output logic              pinAltSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              wrIrq,
  output logic [DATA_W-1:0] cmdCopy,
  output logic [ADDR_W-1:0] addrCopy,
  output logic              spiFlag,
  input  logic              fwFlagWe,
  input  logic              fwFlagWdata
);

  logic [2:0] pinSync;
  logic       csSync, sckSync, mosiSync;
  logic       active, cmdIsRead, misoBit;
  strobe_t    stb;

  spi_bridge_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, sclk, mosi}),
    .dout(pinSync)
  );

  assign {csSync, sckSync, mosiSync} = pinSync;

  spi_bridge_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .portEn   (portEn),
    .csSync   (csSync),
    .sckSync  (sckSync),
    .cmdIsRead(cmdIsRead),
    .stb      (stb),
    .active   (active)
  );

  spi_bridge_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .mosiSync   (mosiSync),
    .memRdata   (memRdata),
    .fwFlagWe   (fwFlagWe),
    .fwFlagWdata(fwFlagWdata),
    .cmdIsRead  (cmdIsRead),
    .cmdCopy    (cmdCopy),
    .addrCopy   (addrCopy),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memWe      (memWe),
    .memRe      (memRe),
    .wrIrq      (wrIrq),
    .misoBit    (misoBit),
    .spiFlag    (spiFlag)
  );

  assign misoOut   = misoBit;
  assign misoOe    = active;
  assign pinAltSel = ~portEn;

endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk (
  input logic clk,
  input logic rstN,
  input logic portEn,
  input logic csN,
  input logic misoOe,
  input logic memWe,
  input logic memRe,
  input logic wrIrq,
  input logic spiFlag,
  input logic fwFlagWe,
  input logic fwFlagWdata
);

  // R1
  cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> (!misoOe && !memWe && !memRe));

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!portEn && $past(!portEn)) |-> (!misoOe && !memWe && !memRe));

  // R4
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, memRe}));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiFlag && !(fwFlagWe && !fwFlagWdata)) |=> spiFlag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwFlagWe && !fwFlagWdata && csN && $past(csN) && $past(csN, 2) && $past(csN, 3))
      |=> !spiFlag);

  // R10
  irq_with_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrIrq |-> memWe);

  // R8
  flag_after_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiFlag) |-> csN);

endmodule

bind spi_mem_bridge spi_mem_bridge_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .portEn     (portEn),
  .csN        (csN),
  .misoOe     (misoOe),
  .memWe      (memWe),
  .memRe      (memRe),
  .wrIrq      (wrIrq),
  .spiFlag    (spiFlag),
  .fwFlagWe   (fwFlagWe),
  .fwFlagWdata(fwFlagWdata)
);

// File: tb/spi_mem_bridge_test.sv
module spi_mem_bridge_test;

  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portEn = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic        misoOut, misoOe, pinAltSel;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe, memRe;
  logic [7:0]  memRdata = 8'h00;
  logic        wrIrq;
  logic [7:0]  cmdCopy;
  logic [15:0] addrCopy;
  logic        spiFlag;
  logic        fwFlagWe = 1'b0;
  logic        fwFlagWdata = 1'b0;

  int vectors = 0;
  int fails = 0;
  int irqCount = 0;
  int stableCnt = 0;
  logic prevCs = 1'b1, prevEn = 1'b0;
  logic [15:0] expAddrQ[$];
  logic [7:0]  expDataQ[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_mem_bridge uut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .csN(csN), .sclk(sclk), .mosi(mosi),
    .misoOut(misoOut), .misoOe(misoOe), .pinAltSel(pinAltSel),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .wrIrq(wrIrq), .cmdCopy(cmdCopy), .addrCopy(addrCopy),
    .spiFlag(spiFlag), .fwFlagWe(fwFlagWe), .fwFlagWdata(fwFlagWdata)
  );

  function automatic logic [7:0] memVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // local memory model: data one cycle after the read strobe
  always @(posedge clk) if (memRe) memRdata <= memVal(memAddr);

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (csN == prevCs && portEn == prevEn) stableCnt++;
      else stableCnt = 0;
      prevCs = csN;
      prevEn = portEn;
      check(pinAltSel == !portEn, "R2", pinAltSel, !portEn);
      if (stableCnt >= 4) begin
        check(misoOe == (portEn && !csN), "R1", misoOe, portEn && !csN);
        if (!(portEn && !csN)) check(!memWe && !memRe, "R1", {memWe, memRe}, 0);
      end
      if (memWe) begin
        if (expAddrQ.size() == 0) begin
          check(0, "R4/R7 unexpected write", memAddr, 0);
        end else begin
          logic [15:0] ea;
          logic [7:0] ed;
          ea = expAddrQ.pop_front();
          ed = expDataQ.pop_front();
          check(memAddr == ea, "R4 addr", memAddr, ea);
          check(memWdata == ed, "R4 data", memWdata, ed);
        end
      end
      if (wrIrq) irqCount++;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      waitClk(HALF);
      rx = {rx[6:0], misoOut};
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frameOpen();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic frameClose();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(3 * HALF);
  endtask

  task automatic sendHeader(input logic [7:0] cmd, input logic [15:0] addr);
    logic [7:0] rx;
    spiBits(cmd, 8, rx);
    spiBits(addr[15:8], 8, rx);
    spiBits(addr[7:0], 8, rx);
  endtask

  task automatic writeFrame(input logic [7:0] cmd, input logic [15:0] addr, input int n,
                            input bit expectWrites);
    logic [7:0] rx;
    frameOpen();
    sendHeader(cmd, addr);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'h30 + 8'(i * 7);
      if (expectWrites) begin
        expAddrQ.push_back(addr + 16'(i));
        expDataQ.push_back(d);
      end
      spiBits(d, 8, rx);
    end
    frameClose();
  endtask

  task automatic readFrame(input logic [7:0] cmd, input logic [15:0] addr, input int n);
    logic [7:0] rx;
    frameOpen();
    sendHeader(cmd, addr);
    for (int i = 0; i < n; i++) begin
      spiBits(8'h00, 8, rx);
      check(rx == memVal(addr + 16'(i)), "R5 read byte", rx, memVal(addr + 16'(i)));
    end
    frameClose();
  endtask

  task automatic fwFlagWrite(input logic v);
    fwFlagWe = 1'b1;
    fwFlagWdata = v;
    waitClk(1);
    fwFlagWe = 1'b0;
    fwFlagWdata = 1'b0;
    waitClk(2);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int irqBase;
    logic [7:0] rx;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    check(spiFlag == 1'b0, "R9 reset flag", spiFlag, 0);
    check(misoOe == 1'b0, "R1 reset oe", misoOe, 0);
    check(cmdCopy == 8'h00, "R3 reset cmd", cmdCopy, 0);
    check(addrCopy == 16'h0000, "R3 reset addr", addrCopy, 0);
    portEn = 1'b1;
    waitClk(6);

    // write stream, interrupting
    writeFrame(8'h00, 16'h1234, 3, 1);
    check(expAddrQ.size() == 0, "R4 all writes seen", expAddrQ.size(), 0);
    check(spiFlag == 1'b1, "R8 flag after frame", spiFlag, 1);
    check(cmdCopy == 8'h00, "R3 cmd copy", cmdCopy, 8'h00);
    check(addrCopy == 16'h1234, "R6 start addr kept", addrCopy, 16'h1234);
    check(irqCount == 3, "R10 irq per byte", irqCount, 3);

    fwFlagWrite(1'b1);
    check(spiFlag == 1'b1, "R9 write 1 ignored", spiFlag, 1);
    fwFlagWrite(1'b0);
    check(spiFlag == 1'b0, "R9 write 0 clears", spiFlag, 0);

    // silent write
    writeFrame(8'h40, 16'h0010, 2, 1);
    check(expAddrQ.size() == 0, "R4 silent writes seen", expAddrQ.size(), 0);
    check(irqCount == 3, "R10 silent write no irq", irqCount, 3);
    check(cmdCopy == 8'h40, "R3 cmd copy", cmdCopy, 8'h40);

    // read stream across a byte boundary
    irqBase = irqCount;
    readFrame(8'h80, 16'h00FE, 3);
    check(irqCount == irqBase, "R11 read gives no irq", irqCount, irqBase);
    check(addrCopy == 16'h00FE, "R6 read start addr kept", addrCopy, 16'h00FE);

    // read stream wrapping the address space
    readFrame(8'h80, 16'hFFFF, 2);
    check(addrCopy == 16'hFFFF, "R6 wrap start addr", addrCopy, 16'hFFFF);
    fwFlagWrite(1'b0);

    // command-only frame with reserved bits
    frameOpen();
    spiBits(8'hA5, 8, rx);
    frameClose();
    check(spiFlag == 1'b1, "R8 command-only sets flag", spiFlag, 1);
    check(cmdCopy == 8'hA5, "R11 reserved bits captured", cmdCopy, 8'hA5);
    check(addrCopy == 16'hFFFF, "R3 addr copy untouched", addrCopy, 16'hFFFF);
    fwFlagWrite(1'b0);

    // chip-select pulse with no clocks
    frameOpen();
    frameClose();
    check(spiFlag == 1'b0, "R8 empty frame no flag", spiFlag, 0);

    // partial trailing byte
    irqBase = irqCount;
    frameOpen();
    sendHeader(8'h00, 16'h0200);
    expAddrQ.push_back(16'h0200);
    expDataQ.push_back(8'hC3);
    spiBits(8'hC3, 8, rx);
    spiBits(8'h7E, 5, rx);
    frameClose();
    check(expAddrQ.size() == 0, "R7 only full byte written", expAddrQ.size(), 0);
    check(irqCount == irqBase + 1, "R7 one irq only", irqCount, irqBase + 1);
    fwFlagWrite(1'b0);

    // disabled port ignores a frame
    portEn = 1'b0;
    waitClk(6);
    check(pinAltSel == 1'b1, "R2 alt function when disabled", pinAltSel, 1);
    writeFrame(8'h3C, 16'h3000, 2, 0);
    check(spiFlag == 1'b0, "R1 disabled no flag", spiFlag, 0);
    check(cmdCopy == 8'h00, "R1 disabled cmd copy kept", cmdCopy, 8'h00);
    check(addrCopy == 16'h0200, "R1 disabled addr copy kept", addrCopy, 16'h0200);

    // re-enabled port works again
    portEn = 1'b1;
    waitClk(6);
    check(pinAltSel == 1'b0, "R2 port selected", pinAltSel, 0);
    writeFrame(8'h00, 16'hABCD, 1, 1);
    check(expAddrQ.size() == 0, "R4 write after enable", expAddrQ.size(), 0);
    check(addrCopy == 16'hABCD, "R3 addr copy", addrCopy, 16'hABCD);

    waitClk(10);
    finishRun();
  end

endmodule